// File: doc/BRIEF.md
# Packed Saturating and Halving Adder

This unit is a two-stage pipelined adder and subtractor for 32-bit words. Each word is treated as one 32-bit lane, two 16-bit lanes or four 8-bit lanes. Every lane is worked on separately, and no carry crosses from one lane into the next.

It supports two kinds of arithmetic, each in signed and unsigned form. Saturating add and subtract clamp an out-of-range result to the nearest value the lane can hold. Halving add and subtract return the exact sum or difference divided by two, and no carry or borrow bit is lost.

An operation goes in through a valid strobe, an operation code, a lane-mode code and two operands. Its result comes out with a valid strobe exactly two cycles later. A new operation can be issued in every cycle.

Top module: `psat_alu`

## Requirements
- R1: An operation accepted with `in_valid` high at clock edge k drives `out_valid` high with its result after edge k+2, so the latency is exactly two cycles. Operations issued on consecutive cycles come out on consecutive cycles, in order.
- R2: While `rst_n` is low, `out_valid` and `out_result` are both zero.
- R3: The bits of `in_op` have fixed meanings. Bit 0 set selects unsigned operands and clear selects signed. Bit 1 set selects subtract (a−b) and clear selects add. Bit 2 set selects halving and clear selects saturating. The `in_mode` codes are 0 for four 8-bit lanes, 1 for two 16-bit lanes and 2 for one 32-bit lane. Lane i of width w occupies bits [i·w+w−1 : i·w].
- R4: Carries and borrows never cross a lane boundary. Each lane's result depends only on that lane's operand bits.
- R5: An unsigned saturating add whose true sum exceeds 2^w−1 gives all ones in that lane. Otherwise it gives the sum.
- R6: An unsigned saturating subtract whose true difference is negative gives zero in that lane. Otherwise it gives the difference.
- R7: A signed saturating add or subtract whose true result is above 2^(w−1)−1 gives that largest positive value. One below −2^(w−1) gives that most negative value. Otherwise it gives the exact result.
- R8: A halving operation gives bits [w:1] of the exact (w+1)-bit two's-complement sum or difference, which is floor((a±b)/2). For an unsigned halving subtract, that value is read as signed.
- R9: `in_mode` code 3 behaves exactly like code 2, one 32-bit lane.
- R10: A cycle without `in_valid` produces a cycle with `out_valid` low two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code: bit2 halving, bit1 subtract, bit0 unsigned |
| in_mode | input | 2 | Lane split: 0 = 4×8, 1 = 2×16, 2 or 3 = 1×32 |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand (the subtrahend) |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_result | output | 32 | Packed lane results; holds its value while `out_valid` is low |

## Verification
The properties assume that `in_op`, `in_mode`, `in_a` and `in_b` are known, non-X values whenever `in_valid` is high. They also assume that `in_valid` itself is never X once reset is released.

The bounds the properties check are lane-wise only in the single-lane mode. They take for granted that the 32-bit unsigned comparisons describe that mode. Other modes are left to the scoreboard.

The stimulus changes inputs only on the falling clock edge. It drives every field to a defined value in every cycle, including idle ones. Its idle gaps keep `in_valid` at zero instead of leaving it floating.

// File: rtl/psat_pkg.sv
package psat_pkg;

    // Operation code fields: bit2 halving, bit1 subtract, bit0 unsigned.
    typedef struct packed {
        logic halve;
        logic sub;
        logic uns;
    } psat_op_t;

    // Clamp a lane-mode code to the largest lane-width index available.
    function automatic int unsigned psat_width_index(input logic [1:0] mode,
                                                     input int unsigned max_idx);
        int unsigned m;
        m = int'(mode);
        return (m > max_idx) ? max_idx : m;
    endfunction

endpackage

// File: rtl/psat_slice_add.sv
module psat_slice_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         uns,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ext
);
    logic [W-1:0] b_x;
    logic [W:0]   t;
    logic         a_top;
    logic         b_top;

    always_comb begin
        b_x   = sub ? ~b : b;
        t     = {1'b0, a} + {1'b0, b_x} + {{W{1'b0}}, cin};
        sum   = t[W-1:0];
        cout  = t[W];
        // Extension bit of the (W+1)-bit result: only meaningful at a lane top.
        a_top = uns ? 1'b0 : a[W-1];
        b_top = (uns ? 1'b0 : b[W-1]) ^ sub;
        ext   = a_top ^ b_top ^ t[W];
    end
endmodule

// File: rtl/psat_lane_fix.sv
module psat_lane_fix #(
    parameter int W = 8
) (
    input  logic [W-1:0] sum,
    input  logic         ext,
    input  logic         halve,
    input  logic         sub,
    input  logic         uns,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] S_MAX    = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN    = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (halve) begin
            res = {ext, sum[W-1:1]};
        end else if (uns) begin
            if (ext) res = sub ? '0 : ALL_ONES;
            else     res = sum;
        end else begin
            if (ext != sum[W-1]) res = ext ? S_MIN : S_MAX;
            else                 res = sum;
        end
    end
endmodule

// File: rtl/psat_alu.sv
module psat_alu #(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [2:0]                    in_op,
    input  logic [1:0]                    in_mode,
    input  logic [SLICE_W*NUM_SLICES-1:0] in_a,
    input  logic [SLICE_W*NUM_SLICES-1:0] in_b,
    output logic                          out_valid,
    output logic [SLICE_W*NUM_SLICES-1:0] out_result
);
    import psat_pkg::*;

    localparam int DATA_W     = SLICE_W * NUM_SLICES;
    localparam int LOG2_SL    = $clog2(NUM_SLICES);
    localparam int NUM_WIDTHS = LOG2_SL + 1;
    localparam int LW_W       = (NUM_WIDTHS > 1) ? $clog2(NUM_WIDTHS) : 1;

    typedef struct packed {
        logic                  valid;
        psat_op_t              op;
        logic [LW_W-1:0]       lw;
        logic [DATA_W-1:0]     sum;
        logic [NUM_SLICES-1:0] ext;
    } s1_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;

    psat_op_t              op_in;
    logic [LW_W-1:0]       lw_in;
    logic [NUM_SLICES-1:0] lane_start;
    logic [NUM_SLICES-1:0] cin;
    logic [NUM_SLICES-1:0] cout;
    logic [NUM_SLICES-1:0] ext_w;
    logic [DATA_W-1:0]     sum_w;
    logic [DATA_W-1:0]     cand [NUM_WIDTHS];

    // Stage 1: sliced carry chain broken at lane boundaries.
    always_comb begin
        op_in = psat_op_t'(in_op);
        lw_in = LW_W'(psat_width_index(in_mode, LOG2_SL));
        for (int i = 0; i < NUM_SLICES; i++) begin
            lane_start[i] = ((i & ((1 << lw_in) - 1)) == 0);
        end
    end

    generate
        for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
            if (i == 0) begin : g_first
                assign cin[i] = op_in.sub;
            end else begin : g_rest
                assign cin[i] = lane_start[i] ? op_in.sub : cout[i-1];
            end
            psat_slice_add #(.W(SLICE_W)) u_add (
                .a    (in_a[i*SLICE_W +: SLICE_W]),
                .b    (in_b[i*SLICE_W +: SLICE_W]),
                .sub  (op_in.sub),
                .uns  (op_in.uns),
                .cin  (cin[i]),
                .sum  (sum_w[i*SLICE_W +: SLICE_W]),
                .cout (cout[i]),
                .ext  (ext_w[i])
            );
        end
    endgenerate

    // Stage 2: per lane width, clamp or shift each lane.
    generate
        for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
            localparam int LW = SLICE_W << k;
            localparam int NL = NUM_SLICES >> k;
            for (genvar j = 0; j < NL; j++) begin : g_lane
                psat_lane_fix #(.W(LW)) u_fix (
                    .sum   (s1_q.sum[j*LW +: LW]),
                    .ext   (s1_q.ext[(j+1)*(1<<k)-1]),
                    .halve (s1_q.op.halve),
                    .sub   (s1_q.op.sub),
                    .uns   (s1_q.op.uns),
                    .res   (cand[k][j*LW +: LW])
                );
            end
        end
    endgenerate

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = in_valid;
        if (in_valid) begin
            s1_d.op  = op_in;
            s1_d.lw  = lw_in;
            s1_d.sum = sum_w;
            s1_d.ext = ext_w;
        end

        s2_d       = s2_q;
        s2_d.valid = s1_q.valid;
        if (s1_q.valid) begin
            s2_d.result = cand[s1_q.lw];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid  = s2_q.valid;
    assign out_result = s2_q.result;

endmodule

// File: rtl/psat_alu_chk.sv
module psat_alu_chk #(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [2:0]                    in_op,
    input logic [1:0]                    in_mode,
    input logic [SLICE_W*NUM_SLICES-1:0] in_a,
    input logic [SLICE_W*NUM_SLICES-1:0] in_b,
    input logic                          out_valid,
    input logic [SLICE_W*NUM_SLICES-1:0] out_result
);
    localparam int DW = SLICE_W * NUM_SLICES;

    logic [1:0]    v_p;
    logic [2:0]    op_p  [2];
    logic [1:0]    md_p  [2];
    logic [DW-1:0] a_p   [2];
    logic [DW-1:0] b_p   [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_p <= '0;
            for (int i = 0; i < 2; i++) begin
                op_p[i] <= '0;
                md_p[i] <= '0;
                a_p[i]  <= '0;
                b_p[i]  <= '0;
            end
        end else begin
            v_p     <= {v_p[0], in_valid};
            op_p[0] <= in_op;
            md_p[0] <= in_mode;
            a_p[0]  <= in_a;
            b_p[0]  <= in_b;
            op_p[1] <= op_p[0];
            md_p[1] <= md_p[0];
            a_p[1]  <= a_p[0];
            b_p[1]  <= b_p[0];
        end
    end

    logic single;
    assign single = (md_p[1] >= 2'd2);

    // R1, R10
    a_r1_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (out_valid == v_p[1]));

    // R5
    a_r5_uadd_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && single && op_p[1] == 3'b001)
        |-> (out_result >= a_p[1] && out_result >= b_p[1]));

    // R6
    a_r6_usub_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && single && op_p[1] == 3'b011) |-> (out_result <= a_p[1]));

    // R8
    a_r8_uavg_between: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && single && op_p[1] == 3'b101)
        |-> ((out_result >= a_p[1] || out_result >= b_p[1]) &&
             (out_result <= a_p[1] || out_result <= b_p[1])));

    // R7
    a_r7_sadd_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && single && op_p[1] == 3'b000 && !a_p[1][DW-1] && !b_p[1][DW-1])
        |-> !out_result[DW-1]);

endmodule

bind psat_alu psat_alu_chk #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chk (.*);

// File: tb/tb_psat_alu.sv
module tb_psat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [1:0]  in_mode = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int n_chk = 0;
    int n_bad = 0;
    int n_pushed = 0;
    int n_seen = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
        logic [2:0]  op;
        logic [1:0]  mode;
        logic [31:0] a;
        logic [31:0] b;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    psat_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference from the requirements (R3, R5..R9): lane-wise integer arithmetic.
    function automatic logic [31:0] ref_fn(input logic [2:0] op, input logic [1:0] mode,
                                           input logic [31:0] a, input logic [31:0] b);
        int     w;
        longint m, x, y, r, lo, hi, acc;
        w   = (mode == 2'd0) ? 8 : (mode == 2'd1) ? 16 : 32;
        m   = (longint'(1) << w) - 1;
        acc = 0;
        for (int l = 0; l < 32 / w; l++) begin
            x = (longint'(a) >> (l * w)) & m;
            y = (longint'(b) >> (l * w)) & m;
            if (!op[0]) begin
                if (((x >> (w - 1)) & 1) != 0) x = x - (longint'(1) << w);
                if (((y >> (w - 1)) & 1) != 0) y = y - (longint'(1) << w);
                lo = -(longint'(1) << (w - 1));
                hi = (longint'(1) << (w - 1)) - 1;
            end else begin
                lo = 0;
                hi = m;
            end
            r = op[1] ? x - y : x + y;
            if (op[2]) r = r >>> 1;
            else if (r > hi) r = hi;
            else if (r < lo) r = lo;
            acc = acc | ((r & m) << (l * w));
        end
        return acc[31:0];
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [1:0] mode);
        if (mode == 2'd3) return "R9";
        if (op[2])        return "R8";
        if (!op[0])       return "R7";
        if (op[1])        return "R6";
        return "R5";
    endfunction

    task automatic issue(input logic [2:0] op, input logic [1:0] mode,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_mode = mode; in_a = a; in_b = b;
        it.exp = ref_fn(op, mode, a, b);
        it.tag = tag; it.op = op; it.mode = mode; it.a = a; it.b = b;
        sb.push_back(it);
        n_pushed++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_op = '0; in_mode = '0; in_a = '0; in_b = '0;
        end
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                n_seen++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected out_valid", out_result, 32'h0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(out_result === it.exp,
                        $sformatf("%s op=%b mode=%0d a=%h b=%h", it.tag, it.op, it.mode, it.a, it.b),
                        out_result, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    logic [31:0] pat [12] = '{32'h00000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000,
                              32'h00000001, 32'h7F7F7F7F, 32'h80808080, 32'h7FFF7FFF,
                              32'h80008000, 32'h01010101, 32'hFF00FF00, 32'h00FF00FF};

    initial begin
        // R2: reset state
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R2 out_valid in reset", {31'b0, out_valid}, 32'h0);
        chk(out_result === 32'h0, "R2 out_result in reset", out_result, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        chk(out_valid === 1'b0, "R10 idle after reset", {31'b0, out_valid}, 32'h0);

        // R1: exact two-cycle latency for a lone operation
        issue(3'b001, 2'd2, 32'hFFFFFFF0, 32'h00000020, "R1");
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b0, "R1 no output after one cycle", {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        chk(out_valid === 1'b1, "R1 output after two cycles", {31'b0, out_valid}, 32'h1);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 output drops after lone op", {31'b0, out_valid}, 32'h0);

        // R3: each opcode bit in isolation, 8-bit lanes
        issue(3'b000, 2'd0, 32'h7F01FF80, 32'h01010180, "R3 signed add");
        issue(3'b001, 2'd0, 32'h7F01FF80, 32'h01010180, "R3 unsigned add");
        issue(3'b010, 2'd0, 32'h7F01FF80, 32'h01010180, "R3 signed sub");
        issue(3'b100, 2'd0, 32'h7F01FF80, 32'h01010180, "R3 halving add");

        // R4: lane isolation
        issue(3'b001, 2'd0, 32'h00FF00FF, 32'h00010001, "R4 carry stays in byte");
        issue(3'b011, 2'd1, 32'h00010000, 32'h00000001, "R4 borrow stays in half");
        issue(3'b101, 2'd0, 32'hFFFFFFFF, 32'h01010101, "R4 halving carry per byte");

        // Boundary cross product, back-to-back issue
        for (int md = 0; md < 4; md++)
            for (int op = 0; op < 8; op++)
                for (int i = 0; i < 12; i++)
                    for (int j = 0; j < 12; j++)
                        issue(3'(op), 2'(md), pat[i], pat[j], tag_of(3'(op), 2'(md)));

        // Random operands with random idle gaps
        for (int n = 0; n < 2000; n++) begin
            logic [2:0] op;
            logic [1:0] md;
            op = 3'($urandom_range(0, 7));
            md = 2'($urandom_range(0, 3));
            issue(op, md, $urandom(), $urandom(), tag_of(op, md));
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end

        idle(4);
        chk(sb.size() == 0, "R1 all results delivered", 32'(sb.size()), 32'h0);
        chk(n_seen == n_pushed, "R10 result count", 32'(n_seen), 32'(n_pushed));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule